// File: doc/BRIEF.md
# Keyboard Matrix Row Sensor

This block watches a key matrix of five rows and up to eight columns. Software picks which columns take part by writing a column-select register in which a 0 bit selects that column. The block then reports, for each row, whether any selected column in that row has a key held down. The row result is held in a five-bit register that reads 0 for a pressed row, so the value 0x1F means no key is seen. Software runs the scan itself: it steps through the columns by writing the column register and reads back the row result after each step.

An interrupt-status bit is set whenever the row result differs from 0x1F and the one-bit keyboard mask is clear. A registered level interrupt output follows that status, but only while the clock-enable input is high. Access is through a 16-bit register interface with separate read and write strobes. The read data is registered and appears one cycle after the strobe.

Top module: `kbd_row_sense`

## Requirements
- R1: After reset the row result reads 0x001F, the column-select register reads 0x00FF (no column selected), the mask reads 0, the interrupt status reads 0 and `kbd_irq` is 0.
- R2: The row result register samples the matrix on every clock edge. Bit r reads 0 exactly when some column c with column-select bit c equal to 0 has `key_down[r*8+c]` set, and reads 1 otherwise. Bits 15:5 of a row result read are 0. The row result is at offset 0x10.
- R3: A write to offset 0x14 stores `bus_wdata[7:0]` as the column select. Reads at 0x14 return it, with bits 15:8 as 0.
- R4: A write to offset 0x28 stores only `bus_wdata[0]` as the keyboard mask. Reads at 0x28 return that bit in bit 0 and 0 elsewhere.
- R5: The interrupt status at offset 0x20 reads 1 in bit 0 exactly when the row result is not 0x1F and the mask is 0. All other bits read 0.
- R6: `kbd_irq` is a register that, on each clock edge, loads the interrupt status when `clk_en` is 1 and loads 0 when `clk_en` is 0. It therefore lags the row result by one cycle.
- R7: Writes to offsets 0x10 and 0x20, and to any unmapped offset, change no register.
- R8: A read of any offset other than 0x10, 0x14, 0x20 and 0x28 returns 0.
- R9: `bus_rdata` carries the addressed value on the cycle after the edge at which `bus_rd` is sampled high. It is 0 after any edge at which `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Functional clock enable; gates the interrupt output |
| key_down | input | 40 | Key-down flags, bit r*8+c for row r, column c |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| kbd_irq | output | 1 | Level keyboard interrupt |

## Verification
The inline assertions check on every cycle the properties that are local in time. A row result with no hits from the previous cycle must read all ones, and one with hits must not. The column and mask registers must hold across cycles without a write to their own offset. A mask write must store bit 0. The interrupt output must stay low after a disabled cycle and may only be high when the row result showed a key. The idle read bus must return zero. Only the bench scenarios can show the full mapping from keys and column patterns to row bits. They also cover multi-key and cross-row combinations, stepping the columns the way a software scan does, and the recovery of the interrupt when the clock enable comes back.

// File: rtl/kbd_sense_pkg.sv
package kbd_sense_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_ROWS   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_COLSEL = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h28;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ROWS,
    SEL_COLS,
    SEL_STAT,
    SEL_MASK
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_ROWS:   s = SEL_ROWS;
      OFS_COLSEL: s = SEL_COLS;
      OFS_STAT:   s = SEL_STAT;
      OFS_MASK:   s = SEL_MASK;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/kbd_col_match.sv
module kbd_col_match #(
  parameter int ROWS = 5,
  parameter int COLS = 8
) (
  input  logic [ROWS*COLS-1:0] key_down,
  input  logic [COLS-1:0]      col_sel_n,
  output logic [ROWS-1:0]      row_hit
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_hit[r] = |(key_down[r*COLS +: COLS] & ~col_sel_n);
  end
endmodule

// File: rtl/kbd_row_latch.sv
module kbd_row_latch #(
  parameter int ROWS = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ROWS-1:0] row_hit,
  output logic [ROWS-1:0] row_q
);
  always_ff @(posedge clk) begin
    if (rst) row_q <= '1;
    else     row_q <= ~row_hit;
  end

  // R2: no hit in the previous cycle means the latch shows no key
  assert_idle_rows_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(row_hit) == '0) |-> (row_q == '1));

  // R2: a hit in the previous cycle must show as a pressed row
  assert_hit_rows_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(row_hit) != '0) |-> (row_q != '1));
endmodule

// File: rtl/kbd_regs.sv
module kbd_regs
  import kbd_sense_pkg::*;
#(
  parameter int ROWS  = 5,
  parameter int COLS  = 8,
  parameter int REG_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [ROWS-1:0]   row_q,
  input  logic              irq_stat,
  output logic [COLS-1:0]   col_q,
  output logic              mask_q,
  output logic [REG_W-1:0]  bus_rdata
);
  reg_sel_e        sel;
  logic [REG_W-1:0] rd_val;

  assign sel = decode_ofs(bus_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q  <= '1;
      mask_q <= 1'b0;
    end else if (bus_wr) begin
      if (sel == SEL_COLS) col_q  <= bus_wdata[COLS-1:0];
      if (sel == SEL_MASK) mask_q <= bus_wdata[0];
    end
  end

  always_comb begin
    case (sel)
      SEL_ROWS: rd_val = REG_W'(row_q);
      SEL_COLS: rd_val = REG_W'(col_q);
      SEL_STAT: rd_val = REG_W'(irq_stat);
      SEL_MASK: rd_val = REG_W'(mask_q);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_rd ? rd_val : '0;
  end

  // R7: the column select only moves on a write to its own offset
  assert_col_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == OFS_COLSEL) |=> $stable(col_q));

  // R7: the mask only moves on a write to its own offset
  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == OFS_MASK) |=> $stable(mask_q));

  // R4: a mask write keeps bit 0 of the data
  assert_mask_store_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_MASK) |=> (mask_q == $past(bus_wdata[0])));

  // R9: an idle read strobe leaves zero on the bus
  assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: rtl/kbd_irq_gen.sv
module kbd_irq_gen #(
  parameter int ROWS = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clk_en,
  input  logic            irq_stat,
  input  logic [ROWS-1:0] row_q,
  output logic            kbd_irq
);
  always_ff @(posedge clk) begin
    if (rst) kbd_irq <= 1'b0;
    else     kbd_irq <= clk_en & irq_stat;
  end

  // R6: no interrupt after a cycle with the clock enable off
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> !kbd_irq);

  // R5: an interrupt needs a pressed row one cycle earlier
  assert_irq_needs_key_R5: assert property (@(posedge clk) disable iff (rst)
    kbd_irq |-> ($past(row_q) != '1));
endmodule

// File: rtl/kbd_row_sense.sv
module kbd_row_sense
  import kbd_sense_pkg::*;
#(
  parameter int ROWS  = 5,
  parameter int COLS  = 8,
  parameter int REG_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clk_en,
  input  logic [ROWS*COLS-1:0] key_down,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  output logic                 kbd_irq
);
  logic [COLS-1:0] col_q;
  logic            mask_q;
  logic [ROWS-1:0] row_hit;
  logic [ROWS-1:0] row_q;
  logic            irq_stat;

  assign irq_stat = (row_q != '1) & ~mask_q;

  kbd_col_match #(.ROWS(ROWS), .COLS(COLS)) i_match (
    .key_down (key_down),
    .col_sel_n(col_q),
    .row_hit  (row_hit)
  );

  kbd_row_latch #(.ROWS(ROWS)) i_latch (
    .clk    (clk),
    .rst    (rst),
    .row_hit(row_hit),
    .row_q  (row_q)
  );

  kbd_regs #(.ROWS(ROWS), .COLS(COLS), .REG_W(REG_W)) i_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .row_q    (row_q),
    .irq_stat (irq_stat),
    .col_q    (col_q),
    .mask_q   (mask_q),
    .bus_rdata(bus_rdata)
  );

  kbd_irq_gen #(.ROWS(ROWS)) i_irq (
    .clk     (clk),
    .rst     (rst),
    .clk_en  (clk_en),
    .irq_stat(irq_stat),
    .row_q   (row_q),
    .kbd_irq (kbd_irq)
  );

  // R5: a masked block never drives the interrupt
  assert_mask_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    mask_q |=> !kbd_irq);
endmodule

// File: tb/test_kbd_row_sense.sv
module test_kbd_row_sense;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clk_en = 1'b1;
  logic [39:0] key_down = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        kbd_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  kbd_row_sense i_kbd_row_sense (
    .clk(clk), .rst(rst), .clk_en(clk_en), .key_down(key_down),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kbd_irq(kbd_irq)
  );

  always #4 clk = ~clk;

  // behavioural reference, advanced on every edge
  int m_col, m_mask, m_rows, m_irq, m_rdata;

  function automatic int hit_bits(input logic [39:0] k, input int col);
    int h = 0;
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < 8; c++)
        if (k[r*8+c] && ((col >> c) & 1) == 0) h = h | (1 << r);
    return h;
  endfunction

  function automatic int model_read(input int a);
    if (a == 'h10) return m_rows;
    if (a == 'h14) return m_col;
    if (a == 'h20) return (m_rows != 31 && m_mask == 0) ? 1 : 0;
    if (a == 'h28) return m_mask;
    return 0;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      m_col <= 255; m_mask <= 0; m_rows <= 31; m_irq <= 0; m_rdata <= 0;
    end else begin
      m_rows  <= 31 & ~hit_bits(key_down, m_col);
      m_irq   <= (clk_en && m_rows != 31 && m_mask == 0) ? 1 : 0;
      m_rdata <= bus_rd ? model_read(int'(bus_addr)) : 0;
      if (bus_wr && bus_addr == 8'h14) m_col <= int'(bus_wdata[7:0]);
      if (bus_wr && bus_addr == 8'h28) m_mask <= int'(bus_wdata[0]);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(int'(kbd_irq) == m_irq, "R6 kbd_irq vs model", int'(kbd_irq), m_irq);
      check(int'(bus_rdata) == m_rdata, "R9 rdata vs model", int'(bus_rdata), m_rdata);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(int'(bus_rdata) == exp, tag, int'(bus_rdata), exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    rd(8'h10, 'h1F, "R1 row result after reset");
    rd(8'h14, 'hFF, "R1 column select after reset");
    rd(8'h28, 0, "R1 mask after reset");
    rd(8'h20, 0, "R1 status after reset");
    check(kbd_irq == 1'b0, "R1 kbd_irq after reset", int'(kbd_irq), 0);

    // R2 key with no column selected stays invisible
    key_down[2*8+3] = 1'b1;
    idle(2);
    rd(8'h10, 'h1F, "R2 key on deselected column");
    // R3 select column 3
    wr(8'h14, 16'hFFF7);
    rd(8'h14, 'hF7, "R3 column select readback");
    idle(1);
    rd(8'h10, 'h1B, "R2 row 2 pressed on column 3");
    rd(8'h20, 1, "R5 status with key and no mask");
    idle(1);
    check(kbd_irq == 1'b1, "R6 irq raised", int'(kbd_irq), 1);
    // R2 other column: key drops out
    wr(8'h14, 16'h00FE);
    idle(2);
    rd(8'h10, 'h1F, "R2 key outside selected column");
    rd(8'h20, 0, "R5 status with no key");
    // R2 several keys across rows
    key_down[0] = 1'b1;
    key_down[4*8+7] = 1'b1;
    wr(8'h14, 16'h007E);
    idle(2);
    rd(8'h10, 'h0E, "R2 rows 0 and 4 pressed");
    // R2 key release seen without any write
    key_down[0] = 1'b0;
    idle(2);
    rd(8'h10, 'h0F, "R2 row 0 released");
    // R3 upper bits dropped
    wr(8'h14, 16'h1234);
    rd(8'h14, 'h34, "R3 upper bits not stored");
    wr(8'h14, 16'h0000);
    idle(2);
    rd(8'h10, 'h0B, "R2 all columns selected");
    // R4 mask keeps only bit 0
    wr(8'h28, 16'hFFFF);
    rd(8'h28, 1, "R4 mask readback set");
    rd(8'h20, 0, "R5 status masked");
    idle(1);
    check(kbd_irq == 1'b0, "R5 irq masked", int'(kbd_irq), 0);
    wr(8'h28, 16'hFFFE);
    rd(8'h28, 0, "R4 mask readback clear");
    rd(8'h20, 1, "R5 status unmasked");
    // R6 clock enable gating
    clk_en = 1'b0;
    idle(3);
    check(kbd_irq == 1'b0, "R6 irq held low while disabled", int'(kbd_irq), 0);
    rd(8'h20, 1, "R6 status still visible while disabled");
    clk_en = 1'b1;
    idle(2);
    check(kbd_irq == 1'b1, "R6 irq back after enable", int'(kbd_irq), 1);
    // R7 writes to read-only and unmapped offsets
    wr(8'h10, 16'h0000);
    wr(8'h20, 16'h0000);
    wr(8'h3C, 16'h00AA);
    wr(8'h15, 16'h00FF);
    idle(2);
    rd(8'h14, 0, "R7 column select untouched");
    rd(8'h28, 0, "R7 mask untouched");
    rd(8'h10, 'h0B, "R7 row result untouched");
    // R8 unmapped reads
    rd(8'h00, 0, "R8 read offset 0x00");
    rd(8'h3C, 0, "R8 read offset 0x3C");
    rd(8'h24, 0, "R8 read offset 0x24");
    // R9 idle bus returns zero
    idle(1);
    check(bus_rdata == 16'h0, "R9 idle read data", int'(bus_rdata), 0);
    key_down = '0;
    idle(3);
    check(kbd_irq == 1'b0, "R6 irq drops after release", int'(kbd_irq), 0);
    finish_run();
  end
endmodule